// File: doc/BRIEF.md
# Asynchronous Serial Channel with Infrared Line Coding

This block is one full-duplex asynchronous serial channel. It runs from a sub-bit tick at sixteen times the bit rate. A select input picks where that tick comes from: a one-cycle timer pulse, or the rising edges of an external clock pin. The external pin is synchronised before its edges are used. Supported bit rates are 150 to 460800 bit/s, set by the tick supplied. The frame shape is chosen at run time:
- 7 or 8 data bits, sent least significant bit first
- one or two stop bits
- even, odd or no parity

On the transmit side, a one-byte holding register sits in front of the shifter. Software can queue the next byte while the current one is still on the line. On the receive side, a two-entry queue sits behind the shifter. The receiver records overrun, framing and parity faults in sticky flags. Three interrupt lines follow the state of the transmit holding register, the receive queue and the fault flags.

An enable input switches both serial pins to return-to-zero infrared coding. A zero bit is sent as a short high pulse, and a one bit is sent as silence. On the receive side, each pulse is stretched back into a full-width zero bit.

Top module: `sio_channel`

## Requirements
- R1: With `srcSel`=0, every cycle with `timerTick` high is one sub-bit tick and `extClk` is ignored. With `srcSel`=1, every synchronised rising edge of `extClk` is one tick and `timerTick` is ignored. One bit lasts 16 ticks.
- R2: In plain coding the line idles high. A frame is sent in this order:
  - one low start bit
  - the data bits, least significant first: 8 bits when `len8`=1, or the low 7 bits when `len8`=0
  - an optional parity bit
  - one high stop bit, or two when `stop2`=1
- R3: `parMode`=2'b10 selects even parity, where the parity bit makes the count of ones over data plus parity even. `parMode`=2'b11 selects odd parity. `parMode`=2'b00 or 2'b01 sends and expects no parity bit.
- R4: `txReady` is high exactly when the holding register is empty. A byte is accepted on a cycle with `txValid` and `txReady` both high. A second byte can be accepted while the first is still being shifted out, and it is sent right after the first.
- R5: After a falling edge, the receiver checks the line again 8 ticks later. A low pulse shorter than that produces no byte.
- R6: Received bytes enter a two-entry first-in first-out queue. `rxValid` is high while the queue holds a byte, `rxData` shows the oldest byte, and a cycle with `rxValid` and `rxReady` both high removes it. In 7-bit mode, bit 7 of `rxData` is 0.
- R7: If a frame completes while both queue entries are full and nothing is popped in that cycle, the new byte is discarded and `ovrErr` is set. The two stored bytes are unchanged.
- R8: A stop bit sampled low sets `frmErr`. The byte is still queued.
- R9: With parity enabled, a received parity bit that does not match the selected parity sets `parErr`. The byte is still queued.
- R10: `ovrErr`, `frmErr` and `parErr` stay set until a cycle with `errClr` high clears them.
- R11: `irqTxEmpty` equals `txReady`. `irqRxFull` equals `rxValid`. `irqRxErr` is high while any fault flag is set.
- R12: With `irEn`=1, `txPin` idles low. A zero bit is sent as a high pulse lasting the first 3 ticks of the bit, and a one bit is sent as no pulse.
- R13: With `irEn`=1, each rising edge on `rxPin` is received as a zero bit, and bits with no pulse are received as ones. Transmit and receive run at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcSel | input | 1 | Tick source: 0 timer pulse, 1 external clock |
| timerTick | input | 1 | One-cycle tick pulse from a timer |
| extClk | input | 1 | External tick clock, asynchronous |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| stop2 | input | 1 | 1 = two stop bits |
| parMode | input | 2 | Parity select (see R3) |
| irEn | input | 1 | Enable infrared line coding |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | `txData` is offered |
| txReady | output | 1 | Holding register empty |
| rxData | output | 8 | Oldest received byte |
| rxValid | output | 1 | Queue not empty |
| rxReady | input | 1 | Pop the oldest byte |
| errClr | input | 1 | Clear all fault flags |
| ovrErr | output | 1 | Overrun flag |
| frmErr | output | 1 | Framing flag |
| parErr | output | 1 | Parity flag |
| irqTxEmpty | output | 1 | Transmit buffer empty request |
| irqRxFull | output | 1 | Receive data available request |
| irqRxErr | output | 1 | Receive fault request |
| txPin | output | 1 | Serial output |
| rxPin | input | 1 | Serial input, asynchronous |

## Verification
The main function is exercised in three ways:
- **Loopback at several frame shapes.** 8N1, 7E2 and 8O1 each confirm that sender and receiver agree on length, parity and stop count. The 7-bit case also shows that bit 7 is dropped.
- **Direct waveform sampling.** An 8E1 frame is checked bit by bit at `txPin`. This separates a bit-order or parity-polarity fault from one that a symmetric loopback would hide.
- **Hand-built frames.** The bench drives frames with a wrong parity bit, a low stop bit and a short glitch. These separate the parity, framing and start-validation logic.

Three further runs cover the remaining paths. A three-byte burst without popping tells overrun apart from plain queueing. Infrared loopback, together with a count of high cycles on `txPin`, checks pulse width and demodulation. A run on the external clock, with the timer held high, shows which tick source is in use.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // strobes from the frame sequencers to the datapath
  typedef struct packed {
    logic   txTake;      // move holding byte into the shifter
    logic   txShift;     // advance to the next data bit
    phase_t txPhase;     // which field is on the line
    logic   txPulseWin;  // inside the infrared pulse window of a bit
    logic   rxBit;       // sample a data bit
    logic   rxPar;       // sample the parity bit
    logic   rxStop;      // sample a stop bit
    logic   rxDone;      // last stop bit sampled, frame complete
  } strobe_t;

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int PULSE_TICKS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    txPending,
  input  logic    rxLine,
  input  logic    len8,
  input  logic    stop2,
  input  logic    parEn,
  output strobe_t stb
);
  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  logic [CNT_W-1:0] lastBit;
  phase_t afterData;
  assign lastBit   = len8 ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W - 2);
  assign afterData = parEn ? PH_PAR : PH_STOP;

  // transmit sequencer
  phase_t           txPh;
  logic [SUB_W-1:0] txSub;
  logic [CNT_W-1:0] txBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh   <= PH_IDLE;
      txSub  <= '0;
      txBits <= '0;
    end else if (txPh == PH_IDLE) begin
      if (txPending) begin
        txPh   <= PH_START;
        txSub  <= '0;
        txBits <= '0;
      end
    end else if (tick) begin
      if (txSub != SUB_LAST) begin
        txSub <= txSub + 1'b1;
      end else begin
        txSub <= '0;
        case (txPh)
          PH_START: begin
            txPh   <= PH_DATA;
            txBits <= '0;
          end
          PH_DATA: begin
            if (txBits == lastBit) begin
              txPh   <= afterData;
              txBits <= '0;
            end else begin
              txBits <= txBits + 1'b1;
            end
          end
          PH_PAR: begin
            txPh   <= PH_STOP;
            txBits <= '0;
          end
          default: begin
            if (stop2 && txBits == '0) txBits <= CNT_W'(1);
            else txPh <= PH_IDLE;
          end
        endcase
      end
    end
  end

  // receive sequencer
  phase_t           rxPh;
  logic [SUB_W-1:0] rxSub;
  logic [CNT_W-1:0] rxBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh   <= PH_IDLE;
      rxSub  <= '0;
      rxBits <= '0;
    end else if (tick) begin
      case (rxPh)
        PH_IDLE: begin
          if (!rxLine) begin
            rxPh  <= PH_START;
            rxSub <= '0;
          end
        end
        PH_START: begin
          if (rxSub == SUB_MID) begin
            rxSub  <= '0;
            rxBits <= '0;
            rxPh   <= rxLine ? PH_IDLE : PH_DATA;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
        default: begin
          if (rxSub != SUB_LAST) begin
            rxSub <= rxSub + 1'b1;
          end else begin
            rxSub <= '0;
            case (rxPh)
              PH_DATA: begin
                if (rxBits == lastBit) begin
                  rxPh   <= afterData;
                  rxBits <= '0;
                end else begin
                  rxBits <= rxBits + 1'b1;
                end
              end
              PH_PAR: begin
                rxPh   <= PH_STOP;
                rxBits <= '0;
              end
              default: begin
                if (stop2 && rxBits == '0) rxBits <= CNT_W'(1);
                else rxPh <= PH_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  logic rxSample;
  assign rxSample = tick && (rxSub == SUB_LAST) &&
                    (rxPh == PH_DATA || rxPh == PH_PAR || rxPh == PH_STOP);

  always_comb begin
    stb.txTake     = (txPh == PH_IDLE) && txPending;
    stb.txShift    = tick && (txPh == PH_DATA) && (txSub == SUB_LAST);
    stb.txPhase    = txPh;
    stb.txPulseWin = (txPh != PH_IDLE) && (txSub < SUB_W'(PULSE_TICKS));
    stb.rxBit      = rxSample && (rxPh == PH_DATA);
    stb.rxPar      = rxSample && (rxPh == PH_PAR);
    stb.rxStop     = rxSample && (rxPh == PH_STOP);
    stb.rxDone     = rxSample && (rxPh == PH_STOP) && (!stop2 || rxBits != '0);
  end

endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 2,
  parameter int SYNC     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcSel,
  input  logic              timerTick,
  input  logic              extClk,
  input  logic              rxPin,
  input  logic              irEn,
  input  logic              len8,
  input  logic              parOdd,
  input  logic              parEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic              errClr,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              parErr,
  output logic              txPin,
  input  strobe_t           stb,
  output logic              tick,
  output logic              txPending,
  output logic              rxLine
);
  localparam int SUB_W = $clog2(OVS);
  localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int QCNT_W = $clog2(RX_DEPTH + 1);

  // input synchronisers and tick source
  logic [SYNC-1:0] extSy, rxSy;
  logic            extPrev, irPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSy   <= '0;
      rxSy    <= '1;
      extPrev <= 1'b0;
      irPrev  <= 1'b1;
    end else begin
      extSy   <= {extSy[SYNC-2:0], extClk};
      rxSy    <= {rxSy[SYNC-2:0], rxPin};
      extPrev <= extSy[SYNC-1];
      irPrev  <= rxSy[SYNC-1];
    end
  end

  assign tick = srcSel ? (extSy[SYNC-1] & ~extPrev) : timerTick;

  // infrared demodulator: stretch each pulse to one bit of low line
  logic [SUB_W:0] irCnt;
  logic           irRise;
  assign irRise = rxSy[SYNC-1] & ~irPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irCnt <= '0;
    else if (irRise) irCnt <= (SUB_W + 1)'(OVS);
    else if (tick && irCnt != '0) irCnt <= irCnt - 1'b1;
  end

  assign rxLine = irEn ? (irCnt == '0) : rxSy[SYNC-1];

  // transmit holding register and shifter
  logic [DATA_W-1:0] txHold, txSh, holdMasked;
  logic              txFull, txParBit, bitVal;

  assign holdMasked = len8 ? txHold : {1'b0, txHold[DATA_W-2:0]};
  assign txReady    = !txFull;
  assign txPending  = txFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      txFull   <= 1'b0;
      txSh     <= '0;
      txParBit <= 1'b0;
    end else begin
      if (txValid && !txFull) begin
        txHold <= txData;
        txFull <= 1'b1;
      end else if (stb.txTake) begin
        txFull <= 1'b0;
      end
      if (stb.txTake) begin
        txSh     <= holdMasked;
        txParBit <= parOdd ^ (^holdMasked);
      end else if (stb.txShift) begin
        txSh <= {1'b0, txSh[DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    case (stb.txPhase)
      PH_START: bitVal = 1'b0;
      PH_DATA:  bitVal = txSh[0];
      PH_PAR:   bitVal = txParBit;
      default:  bitVal = 1'b1;
    endcase
  end

  assign txPin = irEn ? (!bitVal && stb.txPulseWin) : bitVal;

  // receive shifter and frame checks
  logic [DATA_W-1:0] rxSh, rxByte;
  logic              rxParBit, frmBad, frmNow, parNow;

  assign rxByte = len8 ? rxSh : {1'b0, rxSh[DATA_W-1:1]};
  assign frmNow = stb.rxDone && (frmBad || !rxLine);
  assign parNow = stb.rxDone && parEn && (rxParBit != (parOdd ^ (^rxByte)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      rxParBit <= 1'b0;
      frmBad   <= 1'b0;
    end else begin
      if (stb.rxBit) rxSh <= {rxLine, rxSh[DATA_W-1:1]};
      if (stb.rxPar) rxParBit <= rxLine;
      if (stb.rxDone) frmBad <= 1'b0;
      else if (stb.rxStop && !rxLine) frmBad <= 1'b1;
    end
  end

  // receive queue
  logic [DATA_W-1:0] queue [RX_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [QCNT_W-1:0] qCount;
  logic              pop, push, drop;

  assign pop     = rxReady && (qCount != '0);
  assign push    = stb.rxDone && ((qCount != QCNT_W'(RX_DEPTH)) || pop);
  assign drop    = stb.rxDone && !push;
  assign rxValid = (qCount != '0);
  assign rxData  = queue[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RX_DEPTH; i++) queue[i] <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (push) begin
        queue[wrPtr] <= rxByte;
        wrPtr        <= wrPtr + 1'b1;
      end
      if (pop) rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // sticky fault flags, a new event wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrErr <= 1'b0;
      frmErr <= 1'b0;
      parErr <= 1'b0;
    end else begin
      ovrErr <= (ovrErr && !errClr) || drop;
      frmErr <= (frmErr && !errClr) || frmNow;
      parErr <= (parErr && !errClr) || parNow;
    end
  end

endmodule

// File: rtl/sio_channel.sv
module sio_channel
  import sio_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int RX_DEPTH    = 2,
  parameter int SYNC        = 2,
  parameter int PULSE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcSel,
  input  logic              timerTick,
  input  logic              extClk,
  input  logic              len8,
  input  logic              stop2,
  input  logic [1:0]        parMode,
  input  logic              irEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic              errClr,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              parErr,
  output logic              irqTxEmpty,
  output logic              irqRxFull,
  output logic              irqRxErr,
  output logic              txPin,
  input  logic              rxPin
);
  strobe_t stb;
  logic    tick, txPending, rxLine;

  sio_ctrl #(
    .OVS(OVS), .DATA_W(DATA_W), .PULSE_TICKS(PULSE_TICKS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .txPending(txPending),
    .rxLine(rxLine), .len8(len8), .stop2(stop2), .parEn(parMode[1]),
    .stb(stb)
  );

  sio_datapath #(
    .OVS(OVS), .DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .SYNC(SYNC)
  ) dp (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .timerTick(timerTick),
    .extClk(extClk), .rxPin(rxPin), .irEn(irEn), .len8(len8),
    .parOdd(parMode[0]), .parEn(parMode[1]), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .errClr(errClr),
    .ovrErr(ovrErr), .frmErr(frmErr), .parErr(parErr), .txPin(txPin),
    .stb(stb), .tick(tick), .txPending(txPending), .rxLine(rxLine)
  );

  assign irqTxEmpty = txReady;
  assign irqRxFull  = rxValid;
  assign irqRxErr   = ovrErr | frmErr | parErr;

endmodule

// File: rtl/sio_channel_chk.sv
module sio_channel_chk (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic rxReady,
  input logic errClr,
  input logic ovrErr,
  input logic frmErr,
  input logic parErr
);
  // R4: the holding register only fills from an offered byte
  a_r4_fill_needs_offer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(txValid));

  // R6: queued data leaves only through a pop
  a_r6_empty_needs_pop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxValid) |-> $past(rxReady));

  // R7: overrun can only be raised while the queue holds data
  a_r7_overrun_when_held: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrErr) |-> $past(rxValid));

  // R10: the flags drop only on a clear
  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrErr) |-> $past(errClr));
  a_r10_frm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frmErr) |-> $past(errClr));
  a_r10_par_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parErr) |-> $past(errClr));
endmodule

bind sio_channel sio_channel_chk chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .rxValid(rxValid), .rxReady(rxReady), .errClr(errClr),
  .ovrErr(ovrErr), .frmErr(frmErr), .parErr(parErr)
);

// File: tb/sio_channel_test.sv
module sio_channel_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcSel = 1'b0, timerTick = 1'b1, extClk = 1'b0;
  logic len8 = 1'b1, stop2 = 1'b0, irEn = 1'b0;
  logic [1:0] parMode = 2'b00;
  logic [7:0] txData = '0;
  logic txValid = 1'b0, rxReady = 1'b0, errClr = 1'b0;
  logic [7:0] rxData;
  logic txReady, rxValid, ovrErr, frmErr, parErr;
  logic irqTxEmpty, irqRxFull, irqRxErr, txPin, rxPin;
  logic loopEn = 1'b1, drvLine = 1'b1, extRun = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign rxPin = loopEn ? txPin : drvLine;

  sio_channel uut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .timerTick(timerTick),
    .extClk(extClk), .len8(len8), .stop2(stop2), .parMode(parMode),
    .irEn(irEn), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .errClr(errClr), .ovrErr(ovrErr), .frmErr(frmErr), .parErr(parErr),
    .irqTxEmpty(irqTxEmpty), .irqRxFull(irqRxFull), .irqRxErr(irqRxErr),
    .txPin(txPin), .rxPin(rxPin)
  );

  // external tick clock: period of four system cycles while running
  initial begin
    forever begin
      @(negedge clk);
      if (extRun) begin
        @(negedge clk);
        extClk = ~extClk;
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitValid(input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      if (rxValid) begin
        got = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic popRx(input int limit, output logic [7:0] d, output bit got);
    waitValid(limit, got);
    d = rxData;
    if (got) begin
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
    end
  endtask

  task automatic clearErr;
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  // bench-driven frame, index 0 first, 16 cycles per bit
  task automatic driveFrame(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      drvLine = bits[i];
      repeat (16) @(negedge clk);
    end
    drvLine = 1'b1;
  endtask

  task automatic loopCase(input string tag, input logic [7:0] b, input logic [7:0] exp);
    logic [7:0] d;
    bit got;
    sendByte(b);
    popRx(600, d, got);
    chk(tag, got && d == exp, int'(d), int'(exp));
    chk({tag, " no fault"}, !ovrErr && !frmErr && !parErr,
        int'({ovrErr, frmErr, parErr}), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R4 reset txReady", txReady == 1'b1, int'(txReady), 1);
    chk("R6 reset rxValid", rxValid == 1'b0, int'(rxValid), 0);
    chk("R2 idle line high", txPin == 1'b1, int'(txPin), 1);
    chk("R11 reset irqs", {irqTxEmpty, irqRxFull, irqRxErr} == 3'b100,
        int'({irqTxEmpty, irqRxFull, irqRxErr}), 4);
  endtask

  task automatic t_frames;
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b00;
    loopCase("R2 8N1 loopback", 8'hA5, 8'hA5);
    len8 = 1'b0; stop2 = 1'b1; parMode = 2'b10;
    loopCase("R6 7E2 loopback drops bit 7", 8'hDA, 8'h5A);
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b11;
    loopCase("R3 8O1 loopback", 8'h3C, 8'h3C);
  endtask

  task automatic t_wave;
    logic [10:0] expBits;
    logic [10:0] seen;
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b10;
    // start 0, 0x53 lsb first, even parity 0, stop 1
    expBits = {1'b1, 1'b0, 8'h53, 1'b0};
    sendByte(8'h53);
    while (txPin) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      seen[i] = txPin;
      repeat (16) @(negedge clk);
    end
    chk("R2 R3 8E1 waveform", seen == expBits, int'(seen), int'(expBits));
    begin
      logic [7:0] d;
      bit got;
      popRx(100, d, got);
    end
  endtask

  task automatic t_buffer;
    logic [7:0] d;
    bit got;
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b00;
    sendByte(8'h11);
    chk("R4 full after accept", txReady == 1'b0, int'(txReady), 0);
    sendByte(8'h22);
    repeat (40) @(negedge clk);
    chk("R4 second byte held during shift", txReady == 1'b0, int'(txReady), 0);
    chk("R11 irqTxEmpty follows", irqTxEmpty == 1'b0, int'(irqTxEmpty), 0);
    popRx(600, d, got);
    chk("R6 first in order", got && d == 8'h11, int'(d), 8'h11);
    popRx(600, d, got);
    chk("R6 second in order", got && d == 8'h22, int'(d), 8'h22);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    bit got;
    sendByte(8'h81);
    sendByte(8'h82);
    sendByte(8'h83);
    repeat (450) @(negedge clk);
    chk("R7 overrun flagged", ovrErr == 1'b1, int'(ovrErr), 1);
    chk("R11 irqRxErr", irqRxErr == 1'b1, int'(irqRxErr), 1);
    chk("R11 irqRxFull", irqRxFull == 1'b1, int'(irqRxFull), 1);
    popRx(10, d, got);
    chk("R7 oldest kept", got && d == 8'h81, int'(d), 8'h81);
    popRx(10, d, got);
    chk("R7 second kept", got && d == 8'h82, int'(d), 8'h82);
    @(negedge clk);
    chk("R7 third discarded", rxValid == 1'b0, int'(rxValid), 0);
    chk("R10 overrun sticky", ovrErr == 1'b1, int'(ovrErr), 1);
    clearErr();
    chk("R10 overrun cleared", ovrErr == 1'b0, int'(ovrErr), 0);
  endtask

  task automatic t_rx_faults;
    logic [7:0] d;
    bit got;
    loopEn = 1'b0;
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b10;
    // 0x0F even parity should be 0, send 1
    driveFrame({5'b0, 1'b1, 1'b1, 8'h0F, 1'b0}, 11);
    popRx(100, d, got);
    chk("R9 byte kept", got && d == 8'h0F, int'(d), 8'h0F);
    chk("R9 parity fault", parErr == 1'b1 && frmErr == 1'b0,
        int'({frmErr, parErr}), 1);
    clearErr();
    chk("R10 parity cleared", parErr == 1'b0, int'(parErr), 0);
    parMode = 2'b00;
    driveFrame({6'b0, 1'b0, 8'h33, 1'b0}, 10);
    repeat (40) @(negedge clk);
    chk("R8 framing fault", frmErr == 1'b1, int'(frmErr), 1);
    popRx(10, d, got);
    chk("R8 byte kept", got && d == 8'h33, int'(d), 8'h33);
    clearErr();
    // short glitch
    drvLine = 1'b0;
    repeat (4) @(negedge clk);
    drvLine = 1'b1;
    repeat (400) @(negedge clk);
    chk("R5 glitch rejected", rxValid == 1'b0, int'(rxValid), 0);
    loopEn = 1'b1;
  endtask

  task automatic t_irda;
    int highs;
    irEn = 1'b1;
    len8 = 1'b1; stop2 = 1'b0; parMode = 2'b00;
    repeat (4) @(negedge clk);
    chk("R12 infrared idle low", txPin == 1'b0, int'(txPin), 0);
    sendByte(8'h00);
    highs = 0;
    for (int i = 0; i < 250; i++) begin
      if (txPin) highs++;
      @(negedge clk);
    end
    chk("R12 pulse cycles for 0x00", highs == 27, highs, 27);
    begin
      logic [7:0] d;
      bit got;
      popRx(100, d, got);
      chk("R13 demodulated zeros", got && d == 8'h00, int'(d), 0);
    end
    loopCase("R13 infrared loopback", 8'hB7, 8'hB7);
    irEn = 1'b0;
  endtask

  task automatic t_extclk;
    logic [7:0] d;
    bit got;
    repeat (20) @(negedge clk);
    srcSel = 1'b1;
    sendByte(8'h69);
    repeat (500) @(negedge clk);
    chk("R1 timer ignored on external source", rxValid == 1'b0, int'(rxValid), 0);
    extRun = 1'b1;
    popRx(2000, d, got);
    chk("R1 external clock frame", got && d == 8'h69, int'(d), 8'h69);
    extRun = 1'b0;
    srcSel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_frames();
    t_wave();
    t_buffer();
    t_overrun();
    t_rx_faults();
    t_irda();
    t_extclk();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule